// File: doc/BRIEF.md
# Coast Window Generator

This block produces a coast signal that a downstream line-locked PLL uses to hold its phase and frequency while horizontal sync is unreliable. In the vertical interval, horizontal sync often carries equalization or serration pulses, and some lines have no pulse at all. The window brackets that interval. It opens a programmed number of line periods before vertical sync begins and closes a programmed number of line periods after vertical sync ends.

The block works in the system clock domain. It takes horizontal and vertical sync that are already selected and made positive-going. It counts horizontal leading edges between successive vertical leading edges, keeps the length of the last complete frame, and uses that length to predict where the next vertical pulse will start. The vertical reference can be the raw input or a filtered copy that drops pulses too short to contain a line edge.

An external coast input can replace the internally generated window. Its active level can be set by hand or inferred automatically from its duty cycle.

Top module: `coast_window_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it, `coast_out` is 0. No frame is measured yet, and the automatic external polarity starts as active-high.
- R2: With internal source, `precoast_lines` = 0 and `postcoast_lines` = 0, `coast_out` equals the selected vertical reference one clock later. On the raw path, that is `vsync_in` delayed by two clocks.
- R3: A horizontal leading edge is a 0-to-1 change of `hsync_in` seen on two successive clocks. The frame length is the number of such edges from one leading edge of the selected vertical reference to the next. An edge detected in the same clock as the vertical leading edge is not counted.
- R4: Once a frame length is known and `precoast_lines` is non-zero, the internal window turns on when the running line count plus `precoast_lines` is at least the last frame length. A precoast value at or above the frame length keeps the window on for the whole frame.
- R5: Until a frame has been measured from one vertical leading edge to the next, no precoast is applied. The window then starts with the vertical reference itself.
- R6: The internal window stays on while the vertical reference is high. After the reference falls, it stays on for exactly `postcoast_lines` further horizontal leading edges and turns off one clock after the last of them.
- R7: With `vs_filter_sel` = 1, a vertical pulse inside which no horizontal leading edge is detected is discarded. Otherwise the filtered reference rises one clock after the first such edge and falls one clock after the registered raw input falls. With `vs_filter_sel` = 0, the raw input is used unchanged, glitches included.
- R8: `use_ext_coast` = 1 routes the external coast, corrected for polarity, to `coast_out`. A value of 0 routes the internal window.
- R9: With `ext_pol_override` = 1, `ext_pol_manual` = 1 treats `ext_coast_in` as active-high and 0 treats it as active-low. The result appears on `coast_out` two clocks after the input.
- R10: With `ext_pol_override` = 0, the polarity is re-judged at the end of every window of 2^DET_W clocks. The input is taken as active-high when fewer than half of the window's samples were high, and as active-low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Selected horizontal sync, active high |
| vsync_in | input | 1 | Selected vertical sync, active high |
| ext_coast_in | input | 1 | External coast request, polarity set by configuration |
| use_ext_coast | input | 1 | 1 = external coast, 0 = internal window |
| vs_filter_sel | input | 1 | 1 = filtered vertical reference, 0 = raw |
| ext_pol_override | input | 1 | 1 = manual external polarity, 0 = automatic |
| ext_pol_manual | input | 1 | Manual polarity, 1 = active high |
| precoast_lines | input | CNT_W | Line periods of coast before predicted vertical sync |
| postcoast_lines | input | CNT_W | Line periods of coast after vertical sync ends |
| coast_out | output | 1 | Coast to the PLL, active high |

## Verification
The assertions check every clock for the relations that hold at all times. Coast covers the vertical reference. With zero extensions, the output tracks the reference. Before the first measurement, nothing precedes the vertical pulse. A filtered pulse only begins at a line edge. Manual external polarity maps the input directly. The exact line on which precoast opens depends on the previous frame's length, and the exact edge on which postcoast closes depends on a count. Automatic polarity settles only after a whole duty-cycle window. These can be shown only by the bench's frame scenarios, where a behavioural model predicts the output clock by clock.

// File: rtl/coast_pkg.sv
package coast_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    // registered views of the sync inputs shared between sub-blocks
    typedef struct packed {
        logic hs_edge;
        logic vs_raw;
        logic vs_filt;
        logic vs_ref;
        logic ext_lvl;
    } sync_taps_t;

    // static configuration bundle
    typedef struct packed {
        logic use_ext;
        logic filt_sel;
        logic pol_override;
        logic pol_manual;
        cnt_t pre;
        cnt_t post;
    } coast_cfg_t;

    // precoast opens when the line count comes within pre lines of the frame end
    function automatic logic pre_reached(input logic [31:0] line,
                                         input logic [31:0] flen,
                                         input cnt_t        pre);
        return (pre != '0) && ((line + 32'(pre)) >= flen);
    endfunction

    function automatic logic apply_pol(input logic lvl, input logic active_high);
        return active_high ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/coast_sync_front.sv
module coast_sync_front
    import coast_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_in,
    input  logic       vsync_in,
    input  logic       ext_in,
    input  logic       filt_sel,
    output sync_taps_t taps
);

    logic hs_q, hs_q2, vs_q, ext_q, filt_q;
    logic hs_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q   <= 1'b0;
            hs_q2  <= 1'b0;
            vs_q   <= 1'b0;
            ext_q  <= 1'b0;
            filt_q <= 1'b0;
        end else begin
            hs_q   <= hsync_in;
            hs_q2  <= hs_q;
            vs_q   <= vsync_in;
            ext_q  <= ext_in;
            // a pulse survives only once a line edge has been seen inside it
            filt_q <= vs_q & (filt_q | hs_edge);
        end
    end

    assign hs_edge = hs_q & ~hs_q2;

    always_comb begin
        taps.hs_edge = hs_edge;
        taps.vs_raw  = vs_q;
        taps.vs_filt = filt_q;
        taps.vs_ref  = filt_sel ? filt_q : vs_q;
        taps.ext_lvl = ext_q;
    end

endmodule

// File: rtl/coast_frame_tracker.sv
module coast_frame_tracker
    import coast_pkg::*;
#(
    parameter int LINE_W = 11
)(
    input  logic clk,
    input  logic rst,
    input  logic hs_edge,
    input  logic vs_ref,
    input  cnt_t pre,
    input  cnt_t post,
    output logic win_on,
    output logic frame_valid,
    output logic post_busy
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic              vs_d;
    logic              seen_vs;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] frame_len;
    cnt_t              post_cnt;
    logic              vs_lead, vs_trail, pre_on;

    assign vs_lead  = vs_ref & ~vs_d;
    assign vs_trail = ~vs_ref & vs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_d        <= 1'b0;
            seen_vs     <= 1'b0;
            frame_valid <= 1'b0;
            line_cnt    <= '0;
            frame_len   <= '0;
        end else begin
            vs_d <= vs_ref;
            if (vs_lead) begin
                seen_vs  <= 1'b1;
                line_cnt <= '0;
                if (seen_vs) begin
                    frame_len   <= line_cnt;
                    frame_valid <= 1'b1;
                end
            end else if (hs_edge && line_cnt != LINE_MAX) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            post_cnt <= '0;
        end else if (vs_trail) begin
            post_cnt <= post;
        end else if (hs_edge && post_cnt != '0) begin
            post_cnt <= post_cnt - 1'b1;
        end
    end

    assign pre_on    = frame_valid &&
                       pre_reached(32'(line_cnt), 32'(frame_len), pre);
    // the trailing-edge clock is covered before the counter loads
    assign post_busy = (post_cnt != '0) || (vs_trail && post != '0);
    assign win_on    = vs_ref | pre_on | post_busy;

endmodule

// File: rtl/coast_ext_polarity.sv
module coast_ext_polarity #(
    parameter int DET_W = 8
)(
    input  logic clk,
    input  logic rst,
    input  logic ext_lvl,
    output logic auto_high
);

    localparam logic [DET_W:0] HALF = (DET_W+1)'(2 ** (DET_W - 1));

    logic [DET_W-1:0] win_cnt;
    logic [DET_W:0]   hi_cnt;
    logic [DET_W:0]   hi_next;

    assign hi_next = hi_cnt + (DET_W+1)'(ext_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt   <= '0;
            hi_cnt    <= '0;
            auto_high <= 1'b1;
        end else begin
            win_cnt <= win_cnt + 1'b1;
            if (win_cnt == '1) begin
                // the asserted level is the one seen less often
                auto_high <= (hi_next < HALF);
                hi_cnt    <= '0;
            end else begin
                hi_cnt <= hi_next;
            end
        end
    end

endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
    import coast_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int DET_W  = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             ext_coast_in,
    input  logic             use_ext_coast,
    input  logic             vs_filter_sel,
    input  logic             ext_pol_override,
    input  logic             ext_pol_manual,
    input  logic [CNT_W-1:0] precoast_lines,
    input  logic [CNT_W-1:0] postcoast_lines,
    output logic             coast_out
);

    coast_cfg_t cfg;
    sync_taps_t taps;
    logic       win_on, frame_valid, post_busy, auto_high, pol_high, ext_act;
    logic       vs_ref, vs_raw, vs_filt, hs_edge, ext_lvl;

    always_comb begin
        cfg.use_ext      = use_ext_coast;
        cfg.filt_sel     = vs_filter_sel;
        cfg.pol_override = ext_pol_override;
        cfg.pol_manual   = ext_pol_manual;
        cfg.pre          = precoast_lines;
        cfg.post         = postcoast_lines;
    end

    coast_sync_front u_front (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .vsync_in (vsync_in),
        .ext_in   (ext_coast_in),
        .filt_sel (cfg.filt_sel),
        .taps     (taps)
    );

    assign vs_ref  = taps.vs_ref;
    assign vs_raw  = taps.vs_raw;
    assign vs_filt = taps.vs_filt;
    assign hs_edge = taps.hs_edge;
    assign ext_lvl = taps.ext_lvl;

    coast_frame_tracker #(.LINE_W(LINE_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .hs_edge     (hs_edge),
        .vs_ref      (vs_ref),
        .pre         (cfg.pre),
        .post        (cfg.post),
        .win_on      (win_on),
        .frame_valid (frame_valid),
        .post_busy   (post_busy)
    );

    coast_ext_polarity #(.DET_W(DET_W)) u_pol (
        .clk       (clk),
        .rst       (rst),
        .ext_lvl   (ext_lvl),
        .auto_high (auto_high)
    );

    assign pol_high = cfg.pol_override ? cfg.pol_manual : auto_high;
    assign ext_act  = apply_pol(ext_lvl, pol_high);

    always_ff @(posedge clk) begin
        if (rst) coast_out <= 1'b0;
        else     coast_out <= cfg.use_ext ? ext_act : win_on;
    end

endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk (
    input logic       clk,
    input logic       rst,
    input logic       use_ext,
    input logic       pol_override,
    input logic       pol_manual,
    input logic [7:0] pre,
    input logic [7:0] post,
    input logic       vs_ref,
    input logic       vs_raw,
    input logic       vs_filt,
    input logic       hs_edge,
    input logic       ext_lvl,
    input logic       frame_valid,
    input logic       post_busy,
    input logic       coast_out
);

    logic ready;
    always_ff @(posedge clk) begin
        if (rst) ready <= 1'b0;
        else     ready <= 1'b1;
    end

    // R2: zero extensions make the output a one-clock copy of the reference
    a_r2_zero_ext_tracks: assert property (@(posedge clk) disable iff (rst)
        ready && $past(!use_ext && pre == 8'd0 && post == 8'd0 && !post_busy)
        |-> coast_out == $past(vs_ref));

    // R6: the window always covers the vertical reference
    a_r6_covers_vsync: assert property (@(posedge clk) disable iff (rst)
        ready && $past(!use_ext && vs_ref) |-> coast_out);

    // R5: before a frame is measured nothing precedes the reference
    a_r5_no_early_pre: assert property (@(posedge clk) disable iff (rst)
        ready && $past(!use_ext && !frame_valid && !post_busy)
        |-> coast_out == $past(vs_ref));

    // R7: a filtered pulse only starts on a line edge inside a raw pulse
    a_r7_filter_edge: assert property (@(posedge clk) disable iff (rst)
        ready && $rose(vs_filt) |-> $past(vs_raw && hs_edge));

    // R9: manual polarity maps the registered external level directly
    a_r9_manual_pol: assert property (@(posedge clk) disable iff (rst)
        ready && $past(use_ext && pol_override)
        |-> coast_out == $past(pol_manual ? ext_lvl : !ext_lvl));

endmodule

bind coast_window_gen coast_window_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .use_ext      (use_ext_coast),
    .pol_override (ext_pol_override),
    .pol_manual   (ext_pol_manual),
    .pre          (precoast_lines),
    .post         (postcoast_lines),
    .vs_ref       (vs_ref),
    .vs_raw       (vs_raw),
    .vs_filt      (vs_filt),
    .hs_edge      (hs_edge),
    .ext_lvl      (ext_lvl),
    .frame_valid  (frame_valid),
    .post_busy    (post_busy),
    .coast_out    (coast_out)
);

// File: tb/sim_coast_window_gen.sv
module sim_coast_window_gen;

    localparam int CLK_PERIOD = 10;
    localparam int HS_PERIOD  = 20;
    localparam int HS_HIGH    = 4;
    localparam int LINES      = 10;
    localparam int VS_LINES   = 2;
    localparam int VS_OFS     = 5;
    localparam int DET_W      = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, ext_coast_in = 1'b0;
    logic       use_ext_coast = 1'b0, vs_filter_sel = 1'b0;
    logic       ext_pol_override = 1'b0, ext_pol_manual = 1'b1;
    logic [7:0] precoast_lines = 8'd0, postcoast_lines = 8'd0;
    logic       coast_out;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coast_window_gen #(.LINE_W(11), .DET_W(DET_W)) u0 (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .ext_coast_in(ext_coast_in), .use_ext_coast(use_ext_coast),
        .vs_filter_sel(vs_filter_sel), .ext_pol_override(ext_pol_override),
        .ext_pol_manual(ext_pol_manual), .precoast_lines(precoast_lines),
        .postcoast_lines(postcoast_lines), .coast_out(coast_out)
    );

    // behavioural reference model, advanced on every rising edge
    bit m_hs1, m_hs2, m_vs1, m_ext1, m_filt, m_vsd, m_seen, m_valid, m_ahigh, m_coast;
    int m_line, m_flen, m_post, m_win, m_hi;

    always @(posedge clk) begin
        if (rst) begin
            m_hs1 = 0; m_hs2 = 0; m_vs1 = 0; m_ext1 = 0; m_filt = 0;
            m_vsd = 0; m_seen = 0; m_valid = 0; m_ahigh = 1; m_coast = 0;
            m_line = 0; m_flen = 0; m_post = 0; m_win = 0; m_hi = 0;
        end else begin
            bit edge_now, ref_now, lead, trail, pre_on, post_on, win, pol, nxt;
            edge_now = m_hs1 && !m_hs2;
            ref_now  = vs_filter_sel ? m_filt : m_vs1;
            lead     = ref_now && !m_vsd;
            trail    = !ref_now && m_vsd;
            pre_on   = m_valid && precoast_lines != 0 &&
                       (m_line + int'(precoast_lines) >= m_flen);
            post_on  = (m_post > 0) || (trail && postcoast_lines != 0);
            win      = ref_now || pre_on || post_on;
            pol      = ext_pol_override ? ext_pol_manual : m_ahigh;
            nxt      = use_ext_coast ? (pol ? m_ext1 : !m_ext1) : win;
            // state updates
            if (m_win == 2**DET_W - 1) begin
                m_ahigh = (m_hi + int'(m_ext1)) < 2**(DET_W-1);
                m_hi = 0; m_win = 0;
            end else begin
                m_hi += int'(m_ext1); m_win++;
            end
            if (trail) m_post = int'(postcoast_lines);
            else if (edge_now && m_post > 0) m_post--;
            if (lead) begin
                if (m_seen) begin m_flen = m_line; m_valid = 1; end
                m_seen = 1; m_line = 0;
            end else if (edge_now) m_line++;
            m_vsd   = ref_now;
            m_filt  = m_vs1 && (m_filt || edge_now);
            m_coast = nxt;
            m_hs2 = m_hs1; m_hs1 = hsync_in; m_vs1 = vsync_in; m_ext1 = ext_coast_in;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (coast_out !== m_coast) begin
                n_bad++;
                $display("FAIL %s: coast_out=%0b expected %0b at %0t",
                         cur_req, coast_out, m_coast, $time);
            end
        end
    end

    // one frame of sync; glitch adds a short vertical pulse with no line edge
    task automatic run_frames(input int n, input bit glitch, input bit ext_inv);
        for (int f = 0; f < n; f++)
            for (int ln = 0; ln < LINES; ln++)
                for (int c = 0; c < HS_PERIOD; c++) begin
                    @(negedge clk);
                    hsync_in = (c < HS_HIGH);
                    vsync_in = (ln < VS_LINES && (ln > 0 || c >= VS_OFS)) ||
                               (ln == VS_LINES && c < VS_OFS) ||
                               (glitch && ln == 5 && c >= 8 && c <= 10);
                    ext_coast_in = (ln < 2) ^ ext_inv;
                end
    endtask

    task automatic do_reset();
        cmp_on = 1'b0;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: output held low in reset
        n_cmp++;
        if (coast_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: coast_out=%0b expected 0 during reset", coast_out);
        end
        rst = 1'b0;
        cmp_on = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        cur_req = "R1"; run_frames(1, 0, 0);
        cur_req = "R2";  // zero extensions on the raw path
        run_frames(3, 0, 0);
        precoast_lines = 8'd2; postcoast_lines = 8'd3;
        do_reset();
        cur_req = "R5"; run_frames(1, 0, 0);
        cur_req = "R3 R4 R6"; run_frames(3, 0, 0);
        precoast_lines = 8'd12; postcoast_lines = 8'd1;
        cur_req = "R4"; run_frames(2, 0, 0);
        precoast_lines = 8'd10; postcoast_lines = 8'd0;
        cur_req = "R4"; run_frames(2, 0, 0);
        precoast_lines = 8'd0; postcoast_lines = 8'd0; vs_filter_sel = 1'b1;
        cur_req = "R7"; run_frames(3, 1, 0);
        vs_filter_sel = 1'b0;
        cur_req = "R7"; run_frames(2, 1, 0);
        use_ext_coast = 1'b1; ext_pol_override = 1'b1; ext_pol_manual = 1'b1;
        cur_req = "R8 R9"; run_frames(2, 0, 0);
        ext_pol_manual = 1'b0;
        cur_req = "R9"; run_frames(2, 0, 1);
        ext_pol_override = 1'b0;
        cur_req = "R10"; run_frames(5, 0, 1);
        cur_req = "R10"; run_frames(3, 0, 0);
        use_ext_coast = 1'b0; postcoast_lines = 8'd4;
        cur_req = "R8 R6"; run_frames(2, 0, 0);
        @(negedge clk);
        cmp_on = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule